// File: doc/BRIEF.md
# Program Memory Lock Guard

This block turns three nonvolatile lock bits into the protection controls for an on-chip program store. It reports whether further programming of the store is refused, whether verify readout is refused, and whether code may be fetched from outside the chip at all. It also filters table reads of code: a read that runs from external code and targets internal code is refused, and returns a blank byte in place of the stored one. The protection levels are cumulative. A higher level keeps every restriction of the levels below it.

The block also owns the external-access strap. While the device reset is held, the strap level is captured. When reset ends and any protection is in force, the captured level is frozen and used from then on. The block then flags any later disagreement between the frozen level and the live pin. With no protection, the live pin is used directly. Between power-up and the first device reset, the strap state is undefined and is reported as not valid.

The strap tracker is a four-state machine:
- `ST_NOSEEN`: power-up, no reset seen yet.
- `ST_SAMPLE`: device reset held, the level is being captured.
- `ST_LOCKED`: protected, the level is frozen.
- `ST_LIVE`: unprotected, the live pin is passed through.

The transitions are:
- `power_on`: any state to `ST_NOSEEN` while `por_n` is low.
- `reset_seen`: any state to `ST_SAMPLE` on a clock edge with `rst` high.
- `release_protected`: `ST_SAMPLE` to `ST_LOCKED` on release with level ≥ 1.
- `release_open`: `ST_SAMPLE` to `ST_LIVE` on release with level 0.

Top module: `pmem_lock_guard`

## Requirements
- R1: Lock bits use the encoding 1 = programmed, with `lock_pgm[0]` as the first bit. Level 0 (none programmed) raises no inhibit. Level 1 (only bit 0) raises `prog_inhibit`. Level 2 (bits 0 and 1) also raises `verify_inhibit`. Level 3 (all bits) also raises `ext_exec_inhibit`.
- R2: The inhibits are cumulative: `ext_exec_inhibit` implies `verify_inhibit`, and `verify_inhibit` implies `prog_inhibit`.
- R3: At level ≥ 1, a table read (`movc_req`=1) issued from an external fetch (`fetch_ext`=1) raises `movc_blocked` and returns `movc_data` = 8'hFF in the same cycle.
- R4: In every other case `movc_blocked` is 0 and `movc_data` equals `code_in`.
- R5: `fetch_denied` is 1 exactly when `fetch_ext` is 1 at level 3.
- R6: Once `por_n` is low, and until the first clock edge with `rst` high, `ea_valid` and `ea_mismatch` are 0.
- R7: After a clock edge with `rst` high, `ea_valid` is 1, `ea_mismatch` is 0 and `ea_eff` follows `ea_pin`. The captured level is `ea_pin` at the last such edge.
- R8: If the level is ≥ 1 at the first edge after reset is released, `ea_eff` holds the captured level. Later changes of `ea_pin` do not change it until the next reset.
- R9: If the level is 0 at that edge, `ea_eff` follows `ea_pin` live.
- R10: In the frozen state, `ea_mismatch` is 1 exactly when `ea_eff` differs from `ea_pin`.
- R11: Any other bit pattern takes the level of its highest programmed bit. For example, 3'b010 gives level 2, and 3'b100 and 3'b110 give level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on, asynchronous, active low; clears the reset history |
| rst | input | 1 | Device reset, synchronous, active high; strap sampling window |
| lock_pgm | input | 3 | Lock bits, 1 = programmed |
| ea_pin | input | 1 | Live external-access strap level |
| fetch_ext | input | 1 | Current fetch is from external program memory |
| movc_req | input | 1 | Table read of internal code requested |
| code_in | input | 8 | Byte read from internal code |
| movc_data | output | 8 | Byte returned to the table read |
| movc_blocked | output | 1 | Table read refused |
| fetch_denied | output | 1 | External fetch refused |
| prog_inhibit | output | 1 | Further programming refused |
| verify_inhibit | output | 1 | Verify readout refused |
| ext_exec_inhibit | output | 1 | External execution refused |
| ea_valid | output | 1 | Strap state defined (a reset has been seen) |
| ea_eff | output | 1 | Effective external-access level |
| ea_mismatch | output | 1 | Frozen strap level disagrees with the live pin |

## Verification
The assertions assume that `por_n` is released only away from a clock edge. They also assume that `lock_pgm` is a nonvolatile value that changes only between steps, never within one. The stimulus changes every input a few nanoseconds after a rising edge and holds it for the whole cycle. It moves the strap pin both inside and outside reset windows. It releases reset under protected, open and irregular lock patterns, so that each state and transition of the strap tracker is entered.

// File: rtl/pmem_lock_pkg.sv
package pmem_lock_pkg;

    typedef enum logic [1:0] {
        LVL_NONE     = 2'd0,
        LVL_NOPROG   = 2'd1,
        LVL_NOVERIFY = 2'd2,
        LVL_NOEXT    = 2'd3
    } prot_level_t;

    typedef enum logic [1:0] {
        ST_NOSEEN = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_LOCKED = 2'd2,
        ST_LIVE   = 2'd3
    } ea_state_t;

endpackage

// File: rtl/lock_level_decode.sv
module lock_level_decode
    import pmem_lock_pkg::*;
#(
    parameter int LOCK_W = 3
) (
    input  logic [LOCK_W-1:0] lock_pgm,
    output prot_level_t       level
);
    localparam int IDX_W = $clog2(LOCK_W + 1);

    logic [LOCK_W-1:0] higher_set;

    // Each bit asks whether it or any higher bit is programmed;
    // the level is the index of the highest programmed bit plus one.
    genvar gi;
    generate
        for (gi = 0; gi < LOCK_W; gi++) begin : g_bit
            if (gi == LOCK_W - 1) begin : g_top
                assign higher_set[gi] = lock_pgm[gi];
            end else begin : g_mid
                assign higher_set[gi] = lock_pgm[gi] | higher_set[gi+1];
            end
        end
    endgenerate

    logic [IDX_W-1:0] count;
    always_comb begin
        count = '0;
        for (int k = 0; k < LOCK_W; k++) begin
            count = count + IDX_W'(higher_set[k]);
        end
        level = prot_level_t'(count[1:0]);
    end

endmodule

// File: rtl/movc_guard.sv
module movc_guard
    import pmem_lock_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  BLANK  = 8'hFF
) (
    input  prot_level_t        level,
    input  logic               fetch_ext,
    input  logic               movc_req,
    input  logic [DATA_W-1:0]  code_in,
    output logic [DATA_W-1:0]  movc_data,
    output logic               movc_blocked,
    output logic               fetch_denied
);
    always_comb begin
        movc_blocked = movc_req && fetch_ext && (level != LVL_NONE);
        fetch_denied = fetch_ext && (level == LVL_NOEXT);
        movc_data    = movc_blocked ? DATA_W'(BLANK) : code_in;
    end

endmodule

// File: rtl/ea_latch_fsm.sv
module ea_latch_fsm
    import pmem_lock_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst,
    input  prot_level_t level,
    input  logic        ea_pin,
    output logic        ea_valid,
    output logic        ea_eff,
    output logic        ea_mismatch
);
    ea_state_t state, state_nx;
    logic      ea_held;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state   <= ST_NOSEEN;
            ea_held <= 1'b0;
        end else begin
            state <= state_nx;
            if (rst) ea_held <= ea_pin;
        end
    end

    always_comb begin
        state_nx = state;
        if (rst) begin
            state_nx = ST_SAMPLE;                       // reset_seen
        end else begin
            unique case (state)
                ST_NOSEEN: state_nx = ST_NOSEEN;
                ST_SAMPLE: state_nx = (level != LVL_NONE) ? ST_LOCKED  // release_protected
                                                          : ST_LIVE;   // release_open
                ST_LOCKED: state_nx = ST_LOCKED;
                ST_LIVE:   state_nx = ST_LIVE;
            endcase
        end
    end

    always_comb begin
        ea_valid    = 1'b1;
        ea_eff      = ea_pin;
        ea_mismatch = 1'b0;
        unique case (state)
            ST_NOSEEN: ea_valid = 1'b0;
            ST_SAMPLE: ea_eff   = ea_pin;
            ST_LOCKED: begin
                ea_eff      = ea_held;
                ea_mismatch = (ea_held != ea_pin);
            end
            ST_LIVE:   ea_eff   = ea_pin;
        endcase
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LOCKED && $past(state) == ST_LOCKED) |-> $stable(ea_held)); // R8
    AST_NO_FLAG_BEFORE_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_NOSEEN) |-> (!ea_valid && !ea_mismatch)); // R6
    AST_RESET_SAMPLES: assert property (@(posedge clk) disable iff (!por_n)
        rst |=> (state == ST_SAMPLE && ea_held == $past(ea_pin))); // R7
    AST_OPEN_NO_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LIVE) |-> !ea_mismatch); // R9

endmodule

// File: rtl/pmem_lock_guard.sv
module pmem_lock_guard
    import pmem_lock_pkg::*;
#(
    parameter int          LOCK_W = 3,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  BLANK  = 8'hFF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst,
    input  logic [LOCK_W-1:0] lock_pgm,
    input  logic              ea_pin,
    input  logic              fetch_ext,
    input  logic              movc_req,
    input  logic [DATA_W-1:0] code_in,
    output logic [DATA_W-1:0] movc_data,
    output logic              movc_blocked,
    output logic              fetch_denied,
    output logic              prog_inhibit,
    output logic              verify_inhibit,
    output logic              ext_exec_inhibit,
    output logic              ea_valid,
    output logic              ea_eff,
    output logic              ea_mismatch
);
    prot_level_t level;

    lock_level_decode #(.LOCK_W(LOCK_W)) u_decode (
        .lock_pgm (lock_pgm),
        .level    (level)
    );

    always_comb begin
        prog_inhibit     = (level != LVL_NONE);
        verify_inhibit   = (level == LVL_NOVERIFY) || (level == LVL_NOEXT);
        ext_exec_inhibit = (level == LVL_NOEXT);
    end

    movc_guard #(.DATA_W(DATA_W), .BLANK(BLANK)) u_movc (
        .level        (level),
        .fetch_ext    (fetch_ext),
        .movc_req     (movc_req),
        .code_in      (code_in),
        .movc_data    (movc_data),
        .movc_blocked (movc_blocked),
        .fetch_denied (fetch_denied)
    );

    ea_latch_fsm u_ea (
        .clk         (clk),
        .por_n       (por_n),
        .rst         (rst),
        .level       (level),
        .ea_pin      (ea_pin),
        .ea_valid    (ea_valid),
        .ea_eff      (ea_eff),
        .ea_mismatch (ea_mismatch)
    );

    AST_VERIFY_NEEDS_PROG: assert property (@(posedge clk) disable iff (!por_n)
        verify_inhibit |-> prog_inhibit); // R2
    AST_EXEC_NEEDS_VERIFY: assert property (@(posedge clk) disable iff (!por_n)
        ext_exec_inhibit |-> verify_inhibit); // R2
    AST_OPEN_PASSTHRU: assert property (@(posedge clk) disable iff (!por_n)
        !movc_blocked |-> (movc_data == code_in)); // R4
    AST_DENY_ONLY_EXT: assert property (@(posedge clk) disable iff (!por_n)
        fetch_denied |-> (fetch_ext && ext_exec_inhibit)); // R5
    AST_BLOCK_NEEDS_PROT: assert property (@(posedge clk) disable iff (!por_n)
        movc_blocked |-> (prog_inhibit && movc_data == 8'hFF)); // R3

endmodule

// File: tb/pmem_lock_guard_bench.sv
module pmem_lock_guard_bench;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst = 1'b0;
    logic [2:0] lock_pgm = 3'b000;
    logic       ea_pin = 1'b0;
    logic       fetch_ext = 1'b0;
    logic       movc_req = 1'b0;
    logic [7:0] code_in = 8'h00;
    logic [7:0] movc_data;
    logic       movc_blocked, fetch_denied, prog_inhibit, verify_inhibit;
    logic       ext_exec_inhibit, ea_valid, ea_eff, ea_mismatch;

    always #5 clk = ~clk;

    pmem_lock_guard u_pmem_lock_guard (
        .clk(clk), .por_n(por_n), .rst(rst), .lock_pgm(lock_pgm),
        .ea_pin(ea_pin), .fetch_ext(fetch_ext), .movc_req(movc_req),
        .code_in(code_in), .movc_data(movc_data), .movc_blocked(movc_blocked),
        .fetch_denied(fetch_denied), .prog_inhibit(prog_inhibit),
        .verify_inhibit(verify_inhibit), .ext_exec_inhibit(ext_exec_inhibit),
        .ea_valid(ea_valid), .ea_eff(ea_eff), .ea_mismatch(ea_mismatch)
    );

    typedef struct {
        string      req;
        logic [7:0] data;
        logic [9:0] flags;
    } exp_t;

    exp_t queue_exp[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference model state: 0 no reset seen, 1 sampling, 2 frozen, 3 live
    int   m_st = 0;
    logic m_held = 1'b0;

    function automatic int lvl_of(logic [2:0] b);
        if (b[2]) return 3;
        if (b[1]) return 2;
        if (b[0]) return 1;
        return 0;
    endfunction

    task automatic step(input logic p, input logic r, input logic [2:0] lk,
                        input logic ea, input logic fx, input logic mr,
                        input logic [7:0] cd, input string req);
        exp_t e;
        int   lv;
        logic blk;
        @(posedge clk);
        // effect of the edge just taken, using the inputs held until now
        if (por_n) begin
            if (rst) begin
                m_st = 1; m_held = ea_pin;
            end else if (m_st == 1) begin
                m_st = (lvl_of(lock_pgm) > 0) ? 2 : 3;
            end
        end
        #2;
        por_n = p; rst = r; lock_pgm = lk; ea_pin = ea;
        fetch_ext = fx; movc_req = mr; code_in = cd;
        if (!p) begin m_st = 0; m_held = 1'b0; end
        lv  = lvl_of(lk);
        blk = mr && fx && (lv > 0);
        e.req  = req;
        e.data = blk ? 8'hFF : cd;
        e.flags = {blk, fx && (lv == 3), lv >= 1, lv >= 2, lv == 3,
                   m_st != 0, (m_st == 2) ? m_held : ea,
                   (m_st == 2) && (m_held != ea), 2'b00};
        queue_exp.push_back(e);
    endtask

    // monitor: compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (queue_exp.size() > 0) begin
                exp_t e;
                logic [9:0] act;
                e = queue_exp.pop_front();
                act = {movc_blocked, fetch_denied, prog_inhibit, verify_inhibit,
                       ext_exec_inhibit, ea_valid, ea_eff, ea_mismatch, 2'b00};
                n_cmp++;
                if (act !== e.flags || movc_data !== e.data) begin
                    n_bad++;
                    $display("FAIL %s: flags=%b data=%h expected flags=%b data=%h",
                             e.req, act, movc_data, e.flags, e.data);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // power-up, no reset yet (R6)
        step(0, 0, 3'b000, 0, 0, 0, 8'h11, "R6");
        step(1, 0, 3'b001, 1, 0, 0, 8'h12, "R6");
        step(1, 0, 3'b001, 0, 0, 0, 8'h13, "R6");
        // reset window with no protection (R7)
        step(1, 1, 3'b000, 1, 0, 0, 8'h21, "R7");
        step(1, 1, 3'b000, 0, 0, 0, 8'h22, "R7");
        step(1, 1, 3'b000, 1, 0, 0, 8'h23, "R7");
        // release open, pin live (R9), passthrough (R4), no inhibits (R1)
        step(1, 0, 3'b000, 1, 0, 0, 8'h31, "R9");
        step(1, 0, 3'b000, 0, 1, 1, 8'h5A, "R4");
        step(1, 0, 3'b000, 1, 1, 1, 8'hA5, "R1");
        step(1, 0, 3'b000, 0, 0, 0, 8'h32, "R9");
        // protected reset with pin high, then freeze (R8, R10)
        step(1, 1, 3'b001, 0, 0, 0, 8'h41, "R7");
        step(1, 1, 3'b001, 1, 0, 0, 8'h42, "R7");
        step(1, 0, 3'b001, 1, 0, 0, 8'h43, "R8");
        step(1, 0, 3'b001, 0, 0, 0, 8'h44, "R10");
        step(1, 0, 3'b001, 0, 0, 0, 8'h45, "R8");
        step(1, 0, 3'b001, 1, 0, 0, 8'h46, "R10");
        // table reads at level 1 (R3, R4)
        step(1, 0, 3'b001, 1, 1, 1, 8'h77, "R3");
        step(1, 0, 3'b001, 1, 0, 1, 8'h78, "R4");
        step(1, 0, 3'b001, 1, 1, 0, 8'h79, "R4");
        // levels 2 and 3 (R1, R2, R5)
        step(1, 0, 3'b011, 1, 0, 0, 8'h81, "R1");
        step(1, 0, 3'b011, 1, 1, 0, 8'h82, "R2");
        step(1, 0, 3'b111, 1, 1, 0, 8'h83, "R5");
        step(1, 0, 3'b111, 1, 0, 1, 8'h84, "R5");
        step(1, 0, 3'b111, 1, 1, 1, 8'h85, "R3");
        // irregular patterns (R11)
        step(1, 0, 3'b010, 1, 1, 1, 8'h91, "R11");
        step(1, 0, 3'b100, 1, 1, 0, 8'h92, "R11");
        step(1, 0, 3'b110, 0, 1, 1, 8'h93, "R11");
        // reset released under an irregular pattern freezes the pin (R11, R8)
        step(1, 1, 3'b100, 0, 0, 0, 8'hA1, "R7");
        step(1, 0, 3'b100, 0, 0, 0, 8'hA2, "R11");
        step(1, 0, 3'b100, 1, 0, 0, 8'hA3, "R10");
        step(1, 0, 3'b100, 1, 0, 0, 8'hA4, "R8");
        // power cycle returns to undefined strap (R6)
        step(0, 0, 3'b001, 0, 0, 0, 8'hB1, "R6");
        step(1, 0, 3'b001, 1, 0, 0, 8'hB2, "R6");
        step(1, 0, 3'b001, 0, 0, 0, 8'hB3, "R6");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule